// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block generates the column address stream for read and write bursts inside a synchronous DRAM model or controller. A mode-load strobe captures a small mode word that chooses the burst length (1, 2, 4, 8 or a whole page), the wrap order (linear or XOR-interleaved) and the CAS latency that sets how long a burst keeps running after a stop request. Each accepted column command latches a start column. From the next cycle on, the block shows one column per clock with a valid flag. It also raises a one-cycle flag on the final column of a fixed-length burst.

A running burst can end early in three ways. A new column command restarts it from a new address. A stop request lets it run one more cycle at latency 2, or two more at latency 3. A precharge aimed at the burst's bank ends it at once. A burst opened with auto-precharge cannot be cut short by a column command or by a same-bank precharge. Such a request is dropped, and a one-cycle illegal flag reports it.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, `col_valid`, `burst_done` and `illegal` are 0. The mode is linear order, length 1, latency 2.
- R2: On `mode_set`, `mode_word[2:0]` selects the length: 000=1, 001=2, 010=4, 011=8, 111=full page of 256 columns. `mode_word[3]` selects the order: 0 linear, 1 interleaved. `mode_word[4]` selects the latency: 0 is latency 2, 1 is latency 3. If the length code is 100, 101 or 110, the whole write is ignored.
- R3: A column command sampled at a clock edge makes the next cycle show `col_valid`=1 and `col_out`=`col_addr`. A new column follows on every clock after that. A fixed-length burst stays valid for exactly BL cycles.
- R4: In linear order, column k of the burst keeps the start bits above the low log2(BL) bits. Its low bits equal (start + k) mod BL.
- R5: In interleaved order at BL 4 or 8, the low log2(BL) bits of column k equal start XOR k. At BL 1 and 2, and in full-page mode, the interleaved setting gives the linear sequence.
- R6: A full-page burst steps through all 256 columns, wraps from 255 to 0, and runs until it is ended. `burst_done` never rises in this mode.
- R7: `burst_done` is 1 exactly in the cycle that shows the last column of a fixed-length burst.
- R8: Column commands are accepted on every clock. Each one restarts the sequence from its own address.
- R9: A stop request keeps the burst valid for 1 more cycle at latency 2 and 2 more cycles at latency 3. The burst is invalid after that, unless it ended earlier by length.
- R10: A precharge whose bank matches the burst's bank makes `col_valid` 0 in the next cycle. A precharge to another bank has no effect.
- R11: While an auto-precharge burst is valid, a column command or a same-bank precharge is ignored and the burst continues. `illegal` is 1 in the following cycle only.
- R12: Length, order and latency are captured at each column command, so a mode load during a burst does not change that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_set | input | 1 | Load `mode_word` into the mode setting |
| mode_word | input | 5 | Length code [2:0], order [3], latency [4] |
| col_cmd | input | 1 | Read or write column command |
| col_addr | input | 8 | Start column of the command |
| auto_pre | input | 1 | Command carries auto-precharge |
| cmd_bank | input | 2 | Bank of the column command |
| burst_stop | input | 1 | Burst stop request |
| precharge | input | 1 | Precharge request |
| pre_bank | input | 2 | Bank of the precharge |
| col_out | output | 8 | Current burst column |
| col_valid | output | 1 | `col_out` holds a burst column |
| burst_done | output | 1 | Last column of a fixed-length burst |
| illegal | output | 1 | A request was refused during an auto-precharge burst |

## Verification
The main sweep runs every fixed length in both orders, starting from each offset inside the burst field, with different upper bits. This separates the linear carry from the XOR pattern, and it shows whether the upper bits are kept across the wrap. A long full-page run from column 250 checks the wrap through 255 to 0 and the absence of a done flag. Stop requests are sent at both latencies, precharges to the matching bank and to another bank, and column commands on every clock. These show apart the tail length, the bank compare and the restart, and each case is tried with and without auto-precharge. A reserved length code and a mode load in the middle of a burst check that the captured setting holds.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;
  localparam int LG_W = 4;

  typedef struct packed {
    logic [LG_W-1:0] lg;
    logic            ilv;
    logic            cl3;
  } burst_cfg_t;
endpackage

// File: rtl/sdram_burst_mode_reg.sv
module sdram_burst_mode_reg
  import sdram_burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_set,
  input  logic [4:0] mode_word,
  output burst_cfg_t cfg
);
  logic [LG_W-1:0] lg_dec;
  logic            rsvd_code;

  always_comb begin
    rsvd_code = 1'b0;
    lg_dec    = '0;
    case (mode_word[2:0])
      3'b000:  lg_dec = LG_W'(0);
      3'b001:  lg_dec = LG_W'(1);
      3'b010:  lg_dec = LG_W'(2);
      3'b011:  lg_dec = LG_W'(3);
      3'b111:  lg_dec = LG_W'(COL_W);
      default: rsvd_code = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (mode_set && !rsvd_code) begin
      cfg.lg  <= lg_dec;
      cfg.ilv <= mode_word[3];
      cfg.cl3 <= mode_word[4];
    end
  end

  AST_RSVD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_set && rsvd_code) |=> $stable(cfg)); // R2
endmodule

// File: rtl/sdram_burst_addr_map.sv
module sdram_burst_addr_map
  import sdram_burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] start,
  input  logic [COL_W-1:0] cnt,
  input  logic [LG_W-1:0]  lg,
  input  logic             ilv,
  output logic [COL_W-1:0] col,
  output logic [COL_W-1:0] mask
);
  logic [COL_W-1:0] lin_sum;
  logic             ilv_on;

  assign mask    = ~({COL_W{1'b1}} << lg);
  assign lin_sum = start + cnt;
  assign ilv_on  = ilv && ((lg == LG_W'(2)) || (lg == LG_W'(3)));

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign col[i] = mask[i] ? (ilv_on ? (start[i] ^ cnt[i]) : lin_sum[i])
                            : start[i];
  end
endmodule

// File: rtl/sdram_burst_ctrl.sv
module sdram_burst_ctrl
  import sdram_burst_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  burst_cfg_t        cfg,
  input  logic              col_cmd,
  input  logic [COL_W-1:0]  col_addr,
  input  logic              auto_pre,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic              burst_stop,
  input  logic              precharge,
  input  logic [BANK_W-1:0] pre_bank,
  output logic              active_o,
  output logic [COL_W-1:0]  start_o,
  output logic [COL_W-1:0]  cnt_o,
  output logic [LG_W-1:0]   lg_o,
  output logic              ilv_o,
  output logic              last_o,
  output logic              illegal_o,
  output logic              start_evt_o
);
  logic              active_q, ap_q, stop_q, tail_q, cl3_q, ilv_q, illegal_q;
  logic [COL_W-1:0]  start_q, cnt_q;
  logic [LG_W-1:0]   lg_q;
  logic [BANK_W-1:0] bank_q;

  logic             full_b, last_b;
  logic             col_blocked, start_evt;
  logic             pre_same, pre_blocked, pre_cut;
  logic             stop_evt, tail_out;
  logic [COL_W-1:0] len_m;

  assign full_b      = (lg_q == LG_W'(COL_W));
  assign len_m       = ~({COL_W{1'b1}} << lg_q);
  assign last_b      = active_q && !full_b && (cnt_q == len_m);
  assign col_blocked = col_cmd && active_q && ap_q;
  assign start_evt   = col_cmd && !col_blocked;
  assign pre_same    = precharge && active_q && (pre_bank == bank_q);
  assign pre_blocked = pre_same && ap_q;
  assign pre_cut     = pre_same && !ap_q;
  assign stop_evt    = burst_stop && active_q && !stop_q;
  assign tail_out    = stop_q && !tail_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      ap_q      <= 1'b0;
      stop_q    <= 1'b0;
      tail_q    <= 1'b0;
      cl3_q     <= 1'b0;
      ilv_q     <= 1'b0;
      illegal_q <= 1'b0;
      start_q   <= '0;
      cnt_q     <= '0;
      lg_q      <= '0;
      bank_q    <= '0;
    end else begin
      illegal_q <= col_blocked || pre_blocked;
      if (start_evt) begin
        active_q <= 1'b1;
        start_q  <= col_addr;
        cnt_q    <= '0;
        lg_q     <= cfg.lg;
        ilv_q    <= cfg.ilv;
        cl3_q    <= cfg.cl3;
        ap_q     <= auto_pre;
        bank_q   <= cmd_bank;
        stop_q   <= 1'b0;
        tail_q   <= 1'b0;
      end else if (active_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (last_b || pre_cut || tail_out) active_q <= 1'b0;
        if (stop_evt) begin
          stop_q <= 1'b1;
          tail_q <= cl3_q;
        end else if (stop_q && tail_q) begin
          tail_q <= 1'b0;
        end
      end
    end
  end

  assign active_o    = active_q;
  assign start_o     = start_q;
  assign cnt_o       = cnt_q;
  assign lg_o        = lg_q;
  assign ilv_o       = ilv_q;
  assign last_o      = last_b;
  assign illegal_o   = illegal_q;
  assign start_evt_o = start_evt;

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (last_b && !start_evt) |=> !active_q); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && $past(active_q) && !$past(start_evt))
      |-> (cnt_q == COL_W'($past(cnt_q) + 1'b1))); // R3
  AST_PRE_CUTS: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_cut && !start_evt) |=> !active_q); // R10
  AST_AP_KEEPS_START: assert property (@(posedge clk) disable iff (!rst_n)
    col_blocked |=> ($stable(start_q) && illegal_q)); // R11
  AST_STOP_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_out && active_q && !start_evt) |=> !active_q); // R9
  AST_FULL_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && (lg_q == LG_W'(COL_W))) |-> !last_o); // R6
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import sdram_burst_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_set,
  input  logic [4:0]        mode_word,
  input  logic              col_cmd,
  input  logic [COL_W-1:0]  col_addr,
  input  logic              auto_pre,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic              burst_stop,
  input  logic              precharge,
  input  logic [BANK_W-1:0] pre_bank,
  output logic [COL_W-1:0]  col_out,
  output logic              col_valid,
  output logic              burst_done,
  output logic              illegal
);
  burst_cfg_t       cfg;
  logic             active, last, start_evt, ilv;
  logic [COL_W-1:0] start, cnt, mask;
  logic [LG_W-1:0]  lg;

  sdram_burst_mode_reg #(.COL_W(COL_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .mode_set(mode_set), .mode_word(mode_word),
    .cfg(cfg)
  );

  sdram_burst_ctrl #(.COL_W(COL_W), .BANK_W(BANK_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg(cfg),
    .col_cmd(col_cmd), .col_addr(col_addr), .auto_pre(auto_pre),
    .cmd_bank(cmd_bank), .burst_stop(burst_stop), .precharge(precharge),
    .pre_bank(pre_bank), .active_o(active), .start_o(start), .cnt_o(cnt),
    .lg_o(lg), .ilv_o(ilv), .last_o(last), .illegal_o(illegal),
    .start_evt_o(start_evt)
  );

  sdram_burst_addr_map #(.COL_W(COL_W)) u_map (
    .start(start), .cnt(cnt), .lg(lg), .ilv(ilv), .col(col_out), .mask(mask)
  );

  assign col_valid  = active;
  assign burst_done = last;

  AST_START_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (col_valid && (col_out == $past(col_addr)))); // R8
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && $past(col_valid) && !$past(start_evt))
      |-> (((col_out ^ $past(col_out)) & ~mask) == '0)); // R4
  AST_DONE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> col_valid); // R7
endmodule

// File: tb/sdram_burst_colgen_tb.sv
module sdram_burst_colgen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_set = 1'b0;
  logic [4:0] mode_word = '0;
  logic       col_cmd = 1'b0;
  logic [7:0] col_addr = '0;
  logic       auto_pre = 1'b0;
  logic [1:0] cmd_bank = '0;
  logic       burst_stop = 1'b0;
  logic       precharge = 1'b0;
  logic [1:0] pre_bank = '0;
  logic [7:0] col_out;
  logic       col_valid, burst_done, illegal;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sdram_burst_colgen u_dut (
    .clk(clk), .rst_n(rst_n), .mode_set(mode_set), .mode_word(mode_word),
    .col_cmd(col_cmd), .col_addr(col_addr), .auto_pre(auto_pre),
    .cmd_bank(cmd_bank), .burst_stop(burst_stop), .precharge(precharge),
    .pre_bank(pre_bank), .col_out(col_out), .col_valid(col_valid),
    .burst_done(burst_done), .illegal(illegal)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected column: offset inside the burst field advanced by k
  function automatic int exp_col(input int s, input int k, input int bl, input bit ilv);
    int base = s - (s % bl);
    if (ilv && bl >= 4) return base + ((s % bl) ^ k);
    return base + (((s % bl) + k) % bl);
  endfunction

  task automatic set_mode(input logic [4:0] w);
    mode_set = 1'b1; mode_word = w;
    @(negedge clk);
    mode_set = 1'b0;
  endtask

  task automatic issue(input logic [7:0] a, input logic ap, input logic [1:0] b);
    col_cmd = 1'b1; col_addr = a; auto_pre = ap; cmd_bank = b;
    @(negedge clk);
    col_cmd = 1'b0; auto_pre = 1'b0;
  endtask

  task automatic run_burst(input int s, input int bl, input bit ilv, input string req);
    issue(8'(s), 1'b0, 2'd0);
    for (int k = 0; k < bl; k++) begin
      chk({req, " valid"}, int'(col_valid), 1);
      chk({req, " col"}, int'(col_out), exp_col(s, k, bl, ilv));
      chk("R7 done", int'(burst_done), (k == bl - 1) ? 1 : 0);
      @(negedge clk);
    end
    chk("R3 end of burst", int'(col_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid", int'(col_valid), 0);
    chk("R1 done", int'(burst_done), 0);
    chk("R1 illegal", int'(illegal), 0);
    run_burst(8'h37, 1, 1'b0, "R1 default length");

    // R4 R5 sweep: all fixed lengths, both orders, every offset
    for (int lc = 0; lc < 4; lc++) begin
      for (int o = 0; o < 2; o++) begin
        set_mode({1'b0, 1'(o), 3'(lc)});
        for (int off = 0; off < (1 << lc); off++) begin
          int s = (((8'h4C * (off + 1)) & 8'hFF) & ~((1 << lc) - 1)) | off;
          run_burst(s, 1 << lc, 1'(o), (o == 1) ? "R5 interleave" : "R4 linear");
        end
      end
    end

    // R2 reserved code ignored: BL4 linear stays
    set_mode(5'b00010);
    set_mode(5'b01101);
    run_burst(8'h21, 4, 1'b0, "R2 reserved");

    // R6 full page from 250 with wrap, then stop at latency 2 (R9)
    set_mode(5'b00111);
    issue(8'd250, 1'b0, 2'd0);
    for (int k = 0; k < 300; k++) begin
      chk("R6 col", int'(col_out), (250 + k) % 256);
      chk("R6 no done", int'(burst_done), 0);
      if (k < 299) @(negedge clk);
    end
    burst_stop = 1'b1;
    @(negedge clk);
    burst_stop = 1'b0;
    chk("R9 cl2 tail valid", int'(col_valid), 1);
    chk("R9 cl2 tail col", int'(col_out), (250 + 300) % 256);
    @(negedge clk);
    chk("R9 cl2 ended", int'(col_valid), 0);

    // R5 full page with interleave bit stays linear
    set_mode(5'b01111);
    issue(8'hFD, 1'b0, 2'd0);
    for (int k = 0; k < 4; k++) begin
      chk("R5 full linear", int'(col_out), (8'hFD + k) % 256);
      @(negedge clk);
    end
    burst_stop = 1'b1;
    @(negedge clk);
    burst_stop = 1'b0;
    @(negedge clk);
    chk("R9 stop ends full page", int'(col_valid), 0);

    // R9 latency 3: two more columns
    set_mode(5'b10011);
    issue(8'h10, 1'b0, 2'd0);
    @(negedge clk);
    @(negedge clk);
    chk("R9 before stop", int'(col_out), 8'h12);
    burst_stop = 1'b1;
    @(negedge clk);
    burst_stop = 1'b0;
    chk("R9 cl3 tail1", int'(col_out), 8'h13);
    chk("R9 cl3 tail1 valid", int'(col_valid), 1);
    @(negedge clk);
    chk("R9 cl3 tail2", int'(col_out), 8'h14);
    chk("R9 cl3 tail2 valid", int'(col_valid), 1);
    @(negedge clk);
    chk("R9 cl3 ended", int'(col_valid), 0);

    // R8 back-to-back column commands
    set_mode(5'b00011);
    col_cmd = 1'b1; col_addr = 8'h05;
    @(negedge clk);
    chk("R8 first", int'(col_out), 8'h05);
    col_addr = 8'h9A;
    @(negedge clk);
    chk("R8 second", int'(col_out), 8'h9A);
    col_addr = 8'h33;
    @(negedge clk);
    col_cmd = 1'b0;
    chk("R8 third", int'(col_out), 8'h33);
    @(negedge clk);
    chk("R8 continue", int'(col_out), 8'h34);

    // R10 precharge: other bank no effect, same bank ends
    issue(8'h10, 1'b0, 2'd2);
    precharge = 1'b1; pre_bank = 2'd0;
    @(negedge clk);
    chk("R10 other bank valid", int'(col_valid), 1);
    chk("R10 other bank col", int'(col_out), 8'h11);
    pre_bank = 2'd2;
    @(negedge clk);
    precharge = 1'b0;
    chk("R10 same bank ends", int'(col_valid), 0);
    chk("R10 no illegal", int'(illegal), 0);

    // R11 auto-precharge burst refuses interrupts
    set_mode(5'b00010);
    issue(8'h40, 1'b1, 2'd1);
    col_cmd = 1'b1; col_addr = 8'h80;
    @(negedge clk);
    col_cmd = 1'b0;
    chk("R11 col refused illegal", int'(illegal), 1);
    chk("R11 col refused col", int'(col_out), 8'h41);
    @(negedge clk);
    chk("R11 illegal one cycle", int'(illegal), 0);
    chk("R11 continues", int'(col_out), 8'h42);
    precharge = 1'b1; pre_bank = 2'd1;
    @(negedge clk);
    precharge = 1'b0;
    chk("R11 pre refused illegal", int'(illegal), 1);
    chk("R11 pre refused col", int'(col_out), 8'h43);
    chk("R11 done at end", int'(burst_done), 1);
    @(negedge clk);
    chk("R11 ended", int'(col_valid), 0);

    // R12 mode load mid-burst leaves running burst
    set_mode(5'b00011);
    issue(8'h60, 1'b0, 2'd0);
    mode_set = 1'b1; mode_word = 5'b00001;
    @(negedge clk);
    mode_set = 1'b0;
    for (int k = 1; k < 8; k++) begin
      chk("R12 col", int'(col_out), 8'h60 + k);
      chk("R12 valid", int'(col_valid), 1);
      @(negedge clk);
    end
    chk("R12 ended", int'(col_valid), 0);
    run_burst(8'h6F, 2, 1'b0, "R12 new length");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule